// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock of an SD/MMC host from the faster kernel clock. A 10-bit divide value `N` sets the card-clock period to `2*N` kernel cycles, with the high and low phases each `N` cycles long. A divide value of zero bypasses the divider, so the card clock follows the kernel clock directly.

Alongside the clock, the block drives a launch strobe for the command and data shifters. The strobe names the kernel cycle whose closing edge produces the card-clock edge on which outputs must change. An edge-select input chooses between the rising and the falling card-clock edge. In bypass, outputs always launch on the falling edge.

A power-save input stops the clock while the bus is idle. Divide and edge-select changes are picked up only at a period boundary, so the clock never shows a shortened pulse.

Top module: `sdclk_gen`

## Requirements
- R1: Reset loads the divide value 1023 (all ones) and drives the card clock low. After reset is released, the clock stays low for 1023 kernel cycles and then high for 1023 kernel cycles.
- R2: With a nonzero divide value N, each high phase and each low phase of the card clock lasts exactly N kernel cycles.
- R3: With N > 0 and `edge_sel_i` = 0, `launch_o` is high for exactly one kernel cycle before each rising card-clock edge, and is low otherwise.
- R4: With N > 0 and `edge_sel_i` = 1, `launch_o` is high for exactly one kernel cycle before each falling card-clock edge, and is low otherwise.
- R5: With a divide value of 0, the card clock is high while the kernel clock is high and low while the kernel clock is low, and `launch_o` is high in every cycle (launch on every falling edge).
- R6: With `pwr_save_i` = 1 and `bus_active_i` = 0, the card clock is held low from the end of the current period onward, and `launch_o` stays low. When `bus_active_i` returns to 1 with `edge_sel_i` = 0, `launch_o` is high in that same cycle and the clock rises at the next kernel edge.
- R7: With `pwr_save_i` = 0, `bus_active_i` has no effect: the clock keeps running with N-cycle phases.
- R8: A divide value changed in mid-period takes effect only at the end of the current card-clock period. Every complete high or low phase therefore lasts either the old or the new N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 10 | Divide value N; 0 selects bypass |
| edge_sel_i | input | 1 | 0: launch on rising card-clock edge, 1: on falling |
| pwr_save_i | input | 1 | Stop the card clock while the bus is idle |
| bus_active_i | input | 1 | Bus transfer in progress |
| card_clk_o | output | 1 | Card clock |
| launch_o | output | 1 | One-cycle strobe ahead of the launch edge |

## Verification
The divider is exercised at the reset value, at N = 1, at small fixed values and at random N from 1 to 24 with both edge selections. Each run measures phase lengths and matches every strobe against the edge that follows it, so an off-by-one in the count and a strobe on the wrong edge are caught separately. Bypass is sampled in both halves of the kernel period, which separates "follows the kernel clock" from "stuck high". A mid-period divide change shows whether any phase is cut short. The power-save case, with the bus idle and then active, shows both the hold-low behaviour and the restart timing. Running with power-save off and the bus idle shows that the bus-active input is ignored.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int unsigned SDCLK_DIV_W = 10;
endpackage

// File: rtl/sdclk_div_core.sv
module sdclk_div_core #(
  parameter int unsigned DIV_W = sdclk_pkg::SDCLK_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             edge_sel_i,
  input  logic             run_i,
  output logic             div_clk_o,
  output logic             byp_o,
  output logic             launch_o
);
  localparam logic [DIV_W-1:0] DIV_RST = '1;

  logic [DIV_W-1:0] cur_n_q, cnt_q;
  logic             div_clk_q, byp_q, neg_q;
  logic             term, period_end, new_zero, rise_launch, fall_launch;

  assign new_zero   = (div_i == '0);
  assign term       = byp_q | (cnt_q == cur_n_q - 1'b1);
  // period ends at the close of the low phase
  assign period_end = term & ~div_clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_n_q   <= DIV_RST;
      cnt_q     <= '0;
      div_clk_q <= 1'b0;
      byp_q     <= 1'b0;
      neg_q     <= 1'b0;
    end else if (period_end) begin
      cur_n_q <= div_i;
      neg_q   <= edge_sel_i;
      byp_q   <= new_zero;
      if (new_zero || byp_q) begin
        div_clk_q <= 1'b0;
        cnt_q     <= '0;
      end else if (run_i) begin
        div_clk_q <= 1'b1;
        cnt_q     <= '0;
      end else begin
        // idle: park on terminal count so restart is immediate
        div_clk_q <= 1'b0;
        cnt_q     <= div_i - 1'b1;
      end
    end else if (term) begin
      div_clk_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rise_launch = period_end & ~byp_q & run_i & ~new_zero & ~edge_sel_i;
  assign fall_launch = term & div_clk_q & neg_q;

  assign div_clk_o = div_clk_q;
  assign byp_o     = byp_q;
  assign launch_o  = rise_launch | fall_launch | (byp_q & run_i);
endmodule

// File: rtl/sdclk_out_gate.sv
module sdclk_out_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic byp_en_i,
  input  logic div_clk_i,
  output logic card_clk_o
);
  logic en_n_q;

  // enable changes only while the kernel clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_n_q <= 1'b0;
    else         en_n_q <= byp_en_i;
  end

  assign card_clk_o = (clk_i & en_n_q) | div_clk_i;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int unsigned DIV_W = sdclk_pkg::SDCLK_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             edge_sel_i,
  input  logic             pwr_save_i,
  input  logic             bus_active_i,
  output logic             card_clk_o,
  output logic             launch_o
);
  logic run, div_clk, byp;

  assign run = ~pwr_save_i | bus_active_i;

  sdclk_div_core #(.DIV_W(DIV_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_i      (div_i),
    .edge_sel_i (edge_sel_i),
    .run_i      (run),
    .div_clk_o  (div_clk),
    .byp_o      (byp),
    .launch_o   (launch_o)
  );

  sdclk_out_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byp_en_i   (byp & run),
    .div_clk_i  (div_clk),
    .card_clk_o (card_clk_o)
  );
endmodule

// File: rtl/sdclk_chk.sv
module sdclk_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_save_i,
  input logic bus_active_i,
  input logic launch_o,
  input logic div_clk,
  input logic byp
);
  assert_rise_launch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o && !byp && !div_clk |=> div_clk);

  assert_fall_launch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o && div_clk |=> !div_clk);

  assert_bypass_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp |-> !div_clk);

  assert_idle_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_save_i && !bus_active_i && !div_clk |=> !div_clk);

  assert_idle_no_launch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_save_i && !bus_active_i && !div_clk |-> !launch_o);
endmodule

bind sdclk_gen sdclk_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwr_save_i   (pwr_save_i),
  .bus_active_i (bus_active_i),
  .launch_o     (launch_o),
  .div_clk      (div_clk),
  .byp          (byp)
);

// File: tb/tb_sdclk_gen.sv
module tb_sdclk_gen;
  localparam int DW = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] div_i = '1;
  logic          edge_sel_i = 1'b0;
  logic          pwr_save_i = 1'b0;
  logic          bus_active_i = 1'b0;
  wire           card_clk_o, launch_o;

  int  checks = 0, fails = 0, prev_n = 1023;
  bit  done = 1'b0;
  logic cs [0:1023];
  logic ls [0:1023];

  always #2 clk_i = ~clk_i;

  sdclk_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .edge_sel_i(edge_sel_i),
    .pwr_save_i(pwr_save_i), .bus_active_i(bus_active_i),
    .card_clk_o(card_clk_o), .launch_o(launch_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic capture(int len);
    for (int k = 0; k < len; k++) begin
      tick();
      cs[k] = card_clk_o;
      ls[k] = launch_o;
    end
  endtask

  // every complete phase must last a or b cycles
  task automatic phases(int len, int a, int b, string req);
    int last = -1, bad = 0, cnt = 0, badlen = a;
    for (int k = 1; k < len; k++) begin
      if (cs[k] != cs[k-1]) begin
        if (last >= 0) begin
          cnt++;
          if (k - last != a && k - last != b) begin bad++; badlen = k - last; end
        end
        last = k;
      end
    end
    chk(bad == 0 && cnt >= 2, req, badlen, a);
  endtask

  function automatic bit exp_launch(bit neg, logic c0, logic c1);
    return neg ? (c0 && !c1) : (!c0 && c1);
  endfunction

  task automatic launches(int len, bit neg, string req);
    int bad = 0;
    for (int k = 0; k < len - 1; k++)
      if (ls[k] != exp_launch(neg, cs[k], cs[k+1])) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic run_div(int n, bit neg);
    div_i = DW'(n);
    edge_sel_i = neg;
    repeat (2*prev_n + 2*n + 6) tick();
    prev_n = n;
    capture(4*n + 6);
    phases(4*n + 6, n, n, "R2");
    launches(4*n + 6, neg, neg ? "R4" : "R3");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lo = 0, hi = 0, bad = 0, wait_n;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk_i);
    #1;
    chk(card_clk_o == 1'b0 && launch_o == 1'b0, "R1 reset state", card_clk_o, 0);
    rst_ni = 1'b1;
    do begin tick(); lo++; end while (card_clk_o == 1'b0 && lo < 3000);
    chk(lo == 1023, "R1 first low phase", lo, 1023);
    do begin tick(); hi++; end while (card_clk_o == 1'b1 && hi < 3000);
    chk(hi == 1023, "R1 first high phase", hi, 1023);

    // directed corners
    run_div(1, 1'b0);
    run_div(1, 1'b1);
    run_div(5, 1'b0);
    run_div(5, 1'b1);
    // random divisors and edges
    for (int i = 0; i < 6; i++) run_div(1 + int'($urandom % 24), bit'($urandom % 2));

    // R5 bypass
    div_i = '0;
    repeat (2*prev_n + 6) tick();
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk_i); #1;
      if (card_clk_o != 1'b1 || launch_o != 1'b1) bad++;
      #2;
      if (card_clk_o != 1'b0) bad++;
    end
    chk(bad == 0, "R5 bypass follows kernel clock", bad, 0);
    prev_n = 1;
    run_div(3, 1'b0);

    // R8 change mid-period
    run_div(6, 1'b0);
    wait_n = int'($urandom % 12);
    repeat (wait_n) tick();
    div_i = DW'(10);
    capture(120);
    phases(120, 6, 10, "R8");
    prev_n = 10;

    // R7 bus idle ignored without power-save
    run_div(4, 1'b0);
    bus_active_i = 1'b0;
    pwr_save_i = 1'b0;
    capture(40);
    phases(40, 4, 4, "R7");

    // R6 power-save with idle bus
    pwr_save_i = 1'b1;
    repeat (12) tick();
    capture(40);
    bad = 0;
    for (int k = 0; k < 40; k++) if (cs[k] != 1'b0 || ls[k] != 1'b0) bad++;
    chk(bad == 0, "R6 held low while idle", bad, 0);
    bus_active_i = 1'b1;
    #1;
    chk(launch_o == 1'b1, "R6 launch on resume", launch_o, 1);
    tick();
    chk(card_clk_o == 1'b1, "R6 rise after resume", card_clk_o, 1);
    capture(40);
    phases(40, 4, 4, "R6 phases after resume");

    finish_run();
  end
endmodule